// File: doc/BRIEF.md
# Three-Voice Square Tone and Noise Generator

The block makes three square-wave tones and one pseudo-random noise stream, gates each voice with a pair of active-low enables, and gives each voice a level. That level is either a fixed 4-bit value or the output of one shared envelope generator. The three levels are summed into one amplitude word, which is registered on every sample tick. The downstream logic turns that word into sound. A sixteen-byte register file sets all of the behaviour. Software writes it through an address/data strobe and reads it back through a registered read port. Two of its bytes also drive two 8-bit general purpose ports, and each port has a direction bit.

All timing comes from the `tick` input. A 4-bit prescaler divides the ticks by 16 into a "step". The tone dividers, the noise divider and the envelope divider all advance on that step.

Top module: `sqtone_gen`

## Requirements
- R1: After reset every register reads 0, `mix_out` is 0 and both port output enables are 0. Ports are in input mode at reset, so offsets 0x0E/0x0F return the pins, which are 0 at that point.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Setting `rd_addr` returns the full stored byte on `rd_data` one clock later, for offsets 0x00–0x0D.
- R3: The tone period of voice A, B or C is {coarse[3:0], fine}, taken from offset pairs 0x01/0x00, 0x03/0x02 and 0x05/0x04. Coarse bits 7:4 are ignored. The square output toggles every 16·P ticks, and P=0 acts as P=1.
- R4: Noise comes from a 17-bit shift register, initialised to 1, that shifts right. Bit 0 is the noise output, and bit 0 XOR bit 3 enters at bit 16. It shifts once every 16·N ticks, where N is offset 0x06 bits 4:0, and N=0 acts as N=1.
- R5: In offset 0x07, bits 0–2 disable tone and bits 3–5 disable noise for voices A–C (1 = disabled). A voice is on when (tone OR tone-disable) AND (noise OR noise-disable).
- R6: For each voice, offsets 0x08–0x0A give the level in bits 3:0, and bit 4 set selects the envelope level instead. `mix_out` is the sum of the levels of the voices that are on. It is registered only on clocks with `tick` high and holds otherwise.
- R7: The envelope advances one level every 16·E ticks, where E = {offset 0x0C, offset 0x0B} and E=0 acts as 1. Writing offset 0x0D restarts the envelope: the level goes to 0 if ATT (bit 2) is set and to 15 otherwise, and the period count restarts.
- R8: Within a cycle the level counts up when ATT is set and down when it is clear. On the event after an end value (15 going up, 0 going down), with CON (bit 3) set and HLD (bit 0) clear, one of two things happens. With ALT (bit 1) set, the direction reverses and the level stays at the end value. With ALT clear, the level jumps back to the start value of the same direction.
- R9: On that same event, CON clear forces the level to 0 and freezes it. CON set with HLD set freezes the level at the end value, or at 15 minus the end value when ALT is set.
- R10: Offset 0x07 bit 6 sets the direction of port A and bit 7 sets port B (1 = output). `port_x_out` always shows offset 0x0E/0x0F and `port_x_oe` shows the direction bit. A read of 0x0E/0x0F returns the stored byte when the port is an output and the input pins when it is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample tick; also the prescaler input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Registered read data |
| port_a_in | input | 8 | Port A input pins |
| port_b_in | input | 8 | Port B input pins |
| port_a_out | output | 8 | Port A output value |
| port_b_out | output | 8 | Port B output value |
| port_a_oe | output | 1 | Port A drives its pins |
| port_b_oe | output | 1 | Port B drives its pins |
| mix_out | output | 6 | Summed amplitude of the three voices |

## Verification
The noise stream has no phase reference at the ports, so its bits cannot be predicted directly. The bench therefore waits for a change in the mixed output, samples in the middle of each shift interval, and checks the sequence against the shift-register recurrence. The enable matrix is checked while the tone and noise values are still known. That is in the first few hundred ticks after reset: the tone periods are set to their maximum, the noise register still holds 1, and later its bit 0 is 0 for sixteen shifts. The envelope cycle ends and their hold/alternate outcomes are reached by sweeping all sixteen shape codes. Each sweep aligns to the first level change after a restart and then samples forty events at mid-step.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;
  localparam int unsigned NREG     = 16;
  localparam int unsigned AW       = 4;
  localparam int unsigned DW       = 8;
  localparam int unsigned NVOICE   = 3;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned TONE_W   = 12;
  localparam int unsigned NOISE_PW = 5;
  localparam int unsigned LFSR_W   = 17;
  localparam int unsigned ENV_PW   = 16;
  localparam int unsigned PRE_W    = 4;
  localparam int unsigned MIX_W    = LVL_W + $clog2(NVOICE + 1);

  localparam logic [AW-1:0] OFF_NOISE  = 4'h6;
  localparam logic [AW-1:0] OFF_MIXCTL = 4'h7;
  localparam logic [AW-1:0] OFF_AMP0   = 4'h8;
  localparam logic [AW-1:0] OFF_EPF    = 4'hB;
  localparam logic [AW-1:0] OFF_EPC    = 4'hC;
  localparam logic [AW-1:0] OFF_SHAPE  = 4'hD;
  localparam logic [AW-1:0] OFF_PA     = 4'hE;
  localparam logic [AW-1:0] OFF_PB     = 4'hF;

  localparam int unsigned DIR_A_BIT = 6;
  localparam int unsigned DIR_B_BIT = 7;
  localparam int unsigned SEL_ENV_BIT = LVL_W;

  typedef struct packed {
    logic cont;
    logic attack;
    logic alt;
    logic hold;
  } shape_t;
endpackage

// File: rtl/sqtone_regs.sv
module sqtone_regs
  import sqtone_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [DW-1:0]                     wr_data,
  input  logic [AW-1:0]                     rd_addr,
  input  logic [DW-1:0]                     pa_in,
  input  logic [DW-1:0]                     pb_in,
  output logic [DW-1:0]                     rd_data,
  output logic [NVOICE-1:0][TONE_W-1:0]     tone_per,
  output logic [NOISE_PW-1:0]               noise_per,
  output logic [NVOICE-1:0]                 tone_off,
  output logic [NVOICE-1:0]                 noise_off,
  output logic [NVOICE-1:0][LVL_W:0]        amp,
  output logic [ENV_PW-1:0]                 env_per,
  output shape_t                            shape,
  output logic                              dir_a,
  output logic                              dir_b,
  output logic [DW-1:0]                     pa_val,
  output logic [DW-1:0]                     pb_val
);
  logic [NREG-1:0][DW-1:0] bank;
  logic [DW-1:0]           rd_mux;

  always_ff @(posedge clk) begin
    if (rst)        bank <= '0;
    else if (wr_en) bank[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_mux = bank[rd_addr];
    if (rd_addr == OFF_PA && !bank[OFF_MIXCTL][DIR_A_BIT]) rd_mux = pa_in;
    if (rd_addr == OFF_PB && !bank[OFF_MIXCTL][DIR_B_BIT]) rd_mux = pb_in;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  for (genvar v = 0; v < NVOICE; v++) begin : g_fields
    assign tone_per[v]  = {bank[2*v+1][TONE_W-DW-1:0], bank[2*v]};
    assign tone_off[v]  = bank[OFF_MIXCTL][v];
    assign noise_off[v] = bank[OFF_MIXCTL][NVOICE+v];
    assign amp[v]       = bank[int'(OFF_AMP0)+v][LVL_W:0];
  end

  assign noise_per = bank[OFF_NOISE][NOISE_PW-1:0];
  assign env_per   = {bank[OFF_EPC], bank[OFF_EPF]};
  assign shape     = shape_t'(bank[OFF_SHAPE][3:0]);
  assign dir_a     = bank[OFF_MIXCTL][DIR_A_BIT];
  assign dir_b     = bank[OFF_MIXCTL][DIR_B_BIT];
  assign pa_val    = bank[OFF_PA];
  assign pb_val    = bank[OFF_PB];
endmodule

// File: rtl/sqtone_div.sv
module sqtone_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic         fire
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff;
  logic         wrap;

  assign eff  = (period == '0) ? W'(1) : period;
  assign wrap = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, eff};
  assign fire = step && wrap;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= wrap ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/sqtone_noise.sv
module sqtone_noise #(
  parameter int unsigned PW = 5,
  parameter int unsigned LW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [PW-1:0] period,
  output logic          nz
);
  logic          fire;
  logic [LW-1:0] sr;

  sqtone_div #(.W(PW)) u_div (
    .clk(clk), .rst(rst), .clr(1'b0), .step(step), .period(period), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst)       sr <= LW'(1);
    else if (fire) sr <= {sr[0] ^ sr[3], sr[LW-1:1]};
  end

  assign nz = sr[0];
endmodule

// File: rtl/sqtone_env.sv
module sqtone_env
  import sqtone_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          restart,
  input  logic [PW-1:0] period,
  input  shape_t        shape,
  output logic [LW-1:0] level,
  output logic          held
);
  localparam logic [LW-1:0] TOP = '1;

  logic fire;
  logic up;
  logic at_end;

  sqtone_div #(.W(PW)) u_div (
    .clk(clk), .rst(rst), .clr(restart), .step(step), .period(period), .fire(fire)
  );

  assign at_end = up ? (level == TOP) : (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      up    <= 1'b0;
      held  <= 1'b1;
    end else if (restart) begin
      up    <= shape.attack;
      level <= shape.attack ? '0 : TOP;
      held  <= 1'b0;
    end else if (fire && !held) begin
      if (!at_end) begin
        level <= up ? level + LW'(1) : level - LW'(1);
      end else if (!shape.cont) begin
        level <= '0;
        held  <= 1'b1;
      end else if (shape.hold) begin
        level <= shape.alt ? ~level : level;
        held  <= 1'b1;
      end else if (shape.alt) begin
        up    <= ~up;
        level <= up ? TOP : '0;
      end else begin
        level <= up ? '0 : TOP;
      end
    end
  end
endmodule

// File: rtl/sqtone_gen.sv
module sqtone_gen
  import sqtone_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [DW-1:0]    port_a_in,
  input  logic [DW-1:0]    port_b_in,
  output logic [DW-1:0]    port_a_out,
  output logic [DW-1:0]    port_b_out,
  output logic             port_a_oe,
  output logic             port_b_oe,
  output logic [MIX_W-1:0] mix_out
);
  logic [NVOICE-1:0][TONE_W-1:0] tone_per;
  logic [NOISE_PW-1:0]           noise_per;
  logic [NVOICE-1:0]             tone_off;
  logic [NVOICE-1:0]             noise_off;
  logic [NVOICE-1:0][LVL_W:0]    amp;
  logic [ENV_PW-1:0]             env_per;
  shape_t                        env_shape;
  logic [PRE_W-1:0]              pre_cnt;
  logic                          step;
  logic [NVOICE-1:0]             sq;
  logic                          nz;
  logic                          env_restart;
  logic [LVL_W-1:0]              env_lvl;
  logic                          env_held;
  logic [MIX_W-1:0]              mix_d;

  sqtone_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pa_in(port_a_in), .pb_in(port_b_in), .rd_data(rd_data),
    .tone_per(tone_per), .noise_per(noise_per), .tone_off(tone_off),
    .noise_off(noise_off), .amp(amp), .env_per(env_per), .shape(env_shape),
    .dir_a(port_a_oe), .dir_b(port_b_oe), .pa_val(port_a_out), .pb_val(port_b_out)
  );

  always_ff @(posedge clk) begin
    if (rst)       pre_cnt <= '0;
    else if (tick) pre_cnt <= pre_cnt + PRE_W'(1);
  end
  assign step = tick && (pre_cnt == '1);

  for (genvar v = 0; v < NVOICE; v++) begin : g_voice
    logic fire;
    logic sq_q;
    sqtone_div #(.W(TONE_W)) u_div (
      .clk(clk), .rst(rst), .clr(1'b0), .step(step), .period(tone_per[v]), .fire(fire)
    );
    always_ff @(posedge clk) begin
      if (rst)       sq_q <= 1'b0;
      else if (fire) sq_q <= ~sq_q;
    end
    assign sq[v] = sq_q;
  end

  sqtone_noise #(.PW(NOISE_PW), .LW(LFSR_W)) u_noise (
    .clk(clk), .rst(rst), .step(step), .period(noise_per), .nz(nz)
  );

  always_ff @(posedge clk) begin
    if (rst) env_restart <= 1'b0;
    else     env_restart <= wr_en && (wr_addr == OFF_SHAPE);
  end

  sqtone_env #(.PW(ENV_PW), .LW(LVL_W)) u_env (
    .clk(clk), .rst(rst), .step(step), .restart(env_restart), .period(env_per),
    .shape(env_shape), .level(env_lvl), .held(env_held)
  );

  always_comb begin
    logic             on_v;
    logic [LVL_W-1:0] lvl_v;
    mix_d = '0;
    for (int v = 0; v < NVOICE; v++) begin
      on_v  = (sq[v] | tone_off[v]) & (nz | noise_off[v]);
      lvl_v = amp[v][SEL_ENV_BIT] ? env_lvl : amp[v][LVL_W-1:0];
      if (on_v) mix_d = mix_d + MIX_W'(lvl_v);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       mix_out <= '0;
    else if (tick) mix_out <= mix_d;
  end
endmodule

// File: rtl/sqtone_chk.sv
module sqtone_chk
  import sqtone_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             step,
  input logic [NVOICE-1:0] sq,
  input logic             nz,
  input logic             restart,
  input shape_t           shape,
  input logic [LVL_W-1:0] env_lvl,
  input logic             env_held,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             port_a_oe,
  input logic             port_b_oe,
  input logic [MIX_W-1:0] mix_out
);
  p_tone_on_step_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sq));

  p_noise_on_step_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(nz));

  p_mix_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mix_out));

  p_env_restart_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!env_held && (env_lvl == ($past(shape.attack) ? LVL_W'(0) : {LVL_W{1'b1}}))));

  p_env_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (env_held && !restart) |=> $stable(env_lvl));

  p_port_dir_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_MIXCTL) |=>
      (port_a_oe == $past(wr_data[DIR_A_BIT]) && port_b_oe == $past(wr_data[DIR_B_BIT])));
endmodule

bind sqtone_gen sqtone_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .step(step), .sq(sq), .nz(nz),
  .restart(env_restart), .shape(env_shape), .env_lvl(env_lvl), .env_held(env_held),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .port_a_oe(port_a_oe), .port_b_oe(port_b_oe), .mix_out(mix_out)
);

// File: tb/tb_sqtone_gen.sv
module tb_sqtone_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] port_a_in = '0;
  logic [7:0] port_b_in = '0;
  logic [7:0] port_a_out, port_b_out;
  logic       port_a_oe, port_b_oe;
  logic [5:0] mix_out;

  int total = 0;
  int fails = 0;

  sqtone_gen dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .port_a_in(port_a_in), .port_b_in(port_b_in), .port_a_out(port_a_out),
    .port_b_out(port_b_out), .port_a_oe(port_a_oe), .port_b_oe(port_b_oe),
    .mix_out(mix_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_change(output int n);
    logic [5:0] prev;
    prev = mix_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mix_out == prev && n < 20000);
  endtask

  task automatic do_reset();
    tick = 1'b0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int env_model(input int s, input int k);
    int con, att, alt, hld, lvl, up, held;
    con = (s >> 3) & 1; att = (s >> 2) & 1; alt = (s >> 1) & 1; hld = s & 1;
    up = att; lvl = att ? 0 : 15; held = 0;
    for (int i = 0; i < k; i++) begin
      if (held == 0) begin
        if (up == 1 && lvl < 15)      lvl = lvl + 1;
        else if (up == 0 && lvl > 0)  lvl = lvl - 1;
        else if (con == 0)            begin lvl = 0; held = 1; end
        else if (hld == 1)            begin if (alt == 1) lvl = 15 - lvl; held = 1; end
        else if (alt == 1)            up = 1 - up;
        else                          lvl = (up == 1) ? 0 : 15;
      end
    end
    return lvl;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int g, n;
    int bits [64];
    int ok, first_bad_act, first_bad_exp;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk("R1 mix_out", mix_out, 0);
    chk("R1 port_a_oe", port_a_oe, 0);
    chk("R1 port_b_oe", port_b_oe, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 0);
    end

    // R5: enable matrix while tone=0 and noise known
    do_reset();
    for (int v = 0; v < 3; v++) begin
      wr(4'(2*v), 8'hFF);
      wr(4'(2*v+1), 8'h0F);
    end
    wr(4'h6, 8'd31);
    wr(4'h8, 8'd1); wr(4'h9, 8'd2); wr(4'hA, 8'd4);
    tick = 1'b1;
    for (int m = 0; m < 64; m++) begin
      wr(4'h7, 8'(m));
      repeat (2) @(negedge clk);
      chk($sformatf("R5 noise=1 ctl=%0d", m), mix_out, m & 7);
    end
    repeat (400) @(negedge clk);
    for (int m = 0; m < 64; m++) begin
      wr(4'h7, 8'(m));
      repeat (2) @(negedge clk);
      chk($sformatf("R5 noise=0 ctl=%0d", m), mix_out, (m & (m >> 3)) & 7);
    end

    // R6: sum of fixed levels and tick gating
    wr(4'h7, 8'h3F);
    wr(4'h8, 8'd5); wr(4'h9, 8'd6); wr(4'hA, 8'd7);
    repeat (3) @(negedge clk);
    chk("R6 sum 5+6+7", mix_out, 18);
    tick = 1'b0;
    wr(4'h8, 8'd1);
    repeat (4) @(negedge clk);
    chk("R6 held without tick", mix_out, 18);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 updated on tick", mix_out, 14);

    // R3: tone half-periods on each voice
    for (int v = 0; v < 3; v++) begin
      int fine [4] = '{8'h01, 8'h03, 8'h00, 8'h05};
      int crs  [4] = '{8'h00, 8'h00, 8'h00, 8'hE1};
      int expp [4] = '{1, 3, 1, 261};
      wr(4'h7, 8'(8'h38 | (7 & ~(1 << v))));
      for (int i = 0; i < 3; i++) wr(4'(8 + i), (i == v) ? 8'd15 : 8'd0);
      for (int p = 0; p < 4; p++) begin
        wr(4'(2*v), 8'(fine[p]));
        wr(4'(2*v+1), 8'(crs[p]));
        repeat (4) @(negedge clk);
        wait_change(n);
        wait_change(g);
        chk($sformatf("R3 voice %0d period %0d gap", v, expp[p]), g, 16 * expp[p]);
      end
    end

    // R4: noise recurrence for two periods
    wr(4'h7, 8'h37);
    wr(4'h8, 8'd15); wr(4'h9, 8'd0); wr(4'hA, 8'd0);
    for (int q = 0; q < 2; q++) begin
      int np, sp;
      np = (q == 0) ? 2 : 0;
      sp = 16 * ((np == 0) ? 1 : np);
      wr(4'h6, 8'(np));
      repeat (4 * sp) @(negedge clk);
      wait_change(n);
      repeat (sp / 2) @(negedge clk);
      for (int k = 0; k < 64; k++) begin
        bits[k] = (mix_out == 15) ? 1 : 0;
        repeat (sp) @(negedge clk);
      end
      ok = 1; first_bad_act = 0; first_bad_exp = 0;
      for (int k = 0; k < 47; k++) begin
        if (ok == 1 && bits[k+17] != (bits[k] ^ bits[k+3])) begin
          ok = 0; first_bad_act = bits[k+17]; first_bad_exp = bits[k] ^ bits[k+3];
        end
      end
      chk($sformatf("R4 noise recurrence period %0d", np),
          ok ? 0 : first_bad_act, ok ? 0 : first_bad_exp);
    end

    // R7: envelope period and restart value
    wr(4'h7, 8'h3F);
    wr(4'h8, 8'h10); wr(4'h9, 8'd0); wr(4'hA, 8'd0);
    wr(4'hB, 8'd4); wr(4'hC, 8'd0);
    wr(4'hD, 8'h08);
    repeat (3) @(negedge clk);
    chk("R7 restart level down", mix_out, 15);
    wait_change(n);
    wait_change(g);
    chk("R7 env step E=4", g, 64);
    wr(4'hB, 8'd0);
    wr(4'hD, 8'h08);
    repeat (3) @(negedge clk);
    wait_change(n);
    wait_change(g);
    chk("R7 env step E=0", g, 16);
    wr(4'hB, 8'd0); wr(4'hC, 8'd1);
    wr(4'hD, 8'h0C);
    repeat (3) @(negedge clk);
    chk("R7 restart level up", mix_out, 0);
    wait_change(n);
    wait_change(g);
    chk("R7 env step E=256", g, 4096);

    // R8/R9: all sixteen shapes
    wr(4'hB, 8'd4); wr(4'hC, 8'd0);
    for (int s = 0; s < 16; s++) begin
      string tag;
      tag = (((s >> 3) & 1) == 0 || (s & 1) == 1) ? "R9" : "R8";
      wr(4'hD, 8'(s));
      repeat (3) @(negedge clk);
      chk($sformatf("%s shape %0d start", tag, s), mix_out, env_model(s, 0));
      wait_change(n);
      repeat (32) @(negedge clk);
      ok = 1; first_bad_act = 0; first_bad_exp = 0;
      for (int k = 1; k <= 40; k++) begin
        if (ok == 1 && mix_out != env_model(s, k)) begin
          ok = 0; first_bad_act = mix_out; first_bad_exp = env_model(s, k);
        end
        repeat (64) @(negedge clk);
      end
      chk($sformatf("%s shape %0d sequence", tag, s),
          ok ? 0 : first_bad_act, ok ? 0 : first_bad_exp);
    end

    // R2: write/read back
    for (int a = 0; a < 14; a++) wr(4'(a), 8'((a * 37 + 11) & 255));
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), d);
      chk($sformatf("R2 reg %0d", a), d, (a * 37 + 11) & 255);
    end

    // R10: ports
    wr(4'h7, 8'hC0);
    wr(4'hE, 8'hA5);
    wr(4'hF, 8'h3C);
    port_a_in = 8'h5A; port_b_in = 8'h69;
    @(negedge clk);
    chk("R10 port_a_out", port_a_out, 8'hA5);
    chk("R10 port_b_out", port_b_out, 8'h3C);
    chk("R10 port_a_oe out", port_a_oe, 1);
    chk("R10 port_b_oe out", port_b_oe, 1);
    rd(4'hE, d); chk("R10 read A output mode", d, 8'hA5);
    rd(4'hF, d); chk("R10 read B output mode", d, 8'h3C);
    wr(4'h7, 8'h80);
    rd(4'hE, d); chk("R10 read A input mode", d, 8'h5A);
    rd(4'hF, d); chk("R10 read B still output", d, 8'h3C);
    wr(4'h7, 8'h00);
    rd(4'hF, d); chk("R10 read B input mode", d, 8'h69);
    chk("R10 port_a_oe in", port_a_oe, 0);
    chk("R10 port_b_oe in", port_b_oe, 0);
    chk("R10 port_a_out kept", port_a_out, 8'hA5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule